// File: doc/BRIEF.md
# Fetch Redirect and Squash Controller

This block sequences instruction fetch for a six-stage in-order pipeline. The stages are two fetch stages (tag check F0 and data read F1), then decode D, execute X, memory M and write-back W. Every control transfer is predicted not taken, so fetch normally walks forward one instruction word per cycle. There is no delay slot. When decode finds a taken jump, or execute finds a taken branch, the block picks the new fetch address and raises kill signals. These signals turn every younger, wrong-path instruction into a bubble.

Jumps resolve one stage earlier than branches, so a jump kills two younger slots (F0, F1) and a branch kills three (F0, F1, D). A branch and a jump can both be taken in the same cycle. In that case the branch is older, so it wins and the jump is squashed with the other wrong-path instructions. While the instruction cache reports a miss, the address in F0 holds. A redirect that arrives during the miss kills its victims at once. The new target is held and fetched as soon as the miss ends.

The block tracks a valid bit per stage, so killed slots travel down the pipe as bubbles. A retired-instruction counter and a cycle counter let software form CPI from real work only.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While reset is held, `fetch_pc` equals `START_ADDR`, `stage_valid` is all zero and both counters are zero. On the first clock edge after reset is released, F0 becomes valid holding `START_ADDR`.
- R2: With no stall and no redirect, a valid F0 is followed by F0 holding `fetch_pc + INSTR_BYTES` on the next edge. A bubble in F0 refetches the same address. `next_pc` always shows the address F0 will hold after the next edge.
- R3: A taken jump with a valid decode stage asserts `kill_f0` and `kill_f1` but not `kill_d`, and makes `next_pc` the jump target.
- R4: A taken branch with a valid execute stage asserts `kill_f0`, `kill_f1` and `kill_d`, and makes `next_pc` the branch target.
- R5: When a valid branch in X and a valid jump in D are both taken in one cycle, the branch target is used and the jump in D is killed.
- R6: A taken indication from a stage that holds a bubble (decode for jumps, execute for branches) raises no kill and does not change `next_pc`.
- R7: While `icache_stall` is high, `fetch_pc` and F0 hold, F1 receives a bubble, and the older stages keep advancing. `fetch_hold` mirrors the stall.
- R8: A redirect that arrives during a stall kills at once and is remembered. When the stall drops, F0 fetches the remembered target, unless a newer redirect arrives in that cycle.
- R9: `stage_valid` bit order is F0=bit0, F1=bit1, D=bit2, X=bit3, M=bit4, W=bit5. Killed slots become bubbles and move down one stage per edge. `retired_count` rises by one on each edge where W is valid, and not otherwise.
- R10: `cycle_count` rises by one on every clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_jump_taken | input | 1 | Decode resolved a taken jump |
| dec_jump_target | input | ADDR_W | Jump destination |
| exe_branch_taken | input | 1 | Execute resolved a taken branch |
| exe_branch_target | input | ADDR_W | Branch destination |
| icache_stall | input | 1 | Instruction cache miss in progress |
| fetch_pc | output | ADDR_W | Address currently held in F0 |
| next_pc | output | ADDR_W | Address F0 will hold after the next edge |
| kill_f0 | output | 1 | Squash the F0 slot |
| kill_f1 | output | 1 | Squash the F1 slot |
| kill_d | output | 1 | Squash the decode slot |
| fetch_hold | output | 1 | Hold enable for PC and F0 |
| stage_valid | output | 6 | Valid bit per stage, F0 at bit 0 |
| retired_count | output | CNT_W | Instructions that left W valid |
| cycle_count | output | CNT_W | Cycles since reset release |

## Verification
Fetch is first run with no control flow to show the start-up refetch and steady sequential stepping. Then isolated jumps and branches are driven, so the two-slot and three-slot squash depths can be told apart. Same-cycle jump and branch pairs expose the priority rule, and taken signals on bubble stages confirm they are ignored. Long randomized runs mix stalls with redirects. These show whether a redirect captured during a miss is fetched when the miss drops, and whether the retired count tracks only surviving instructions.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int unsigned NSTAGE = 6;

  typedef enum int unsigned {
    ST_F0 = 0,
    ST_F1 = 1,
    ST_D  = 2,
    ST_X  = 3,
    ST_M  = 4,
    ST_W  = 5
  } stage_e;

  typedef struct packed {
    logic d;
    logic f1;
    logic f0;
  } kill_t;
endpackage

// File: rtl/fr_redirect_arb.sv
module fr_redirect_arb #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              jump_taken,
  input  logic [ADDR_W-1:0] jump_target,
  input  logic              branch_taken,
  input  logic [ADDR_W-1:0] branch_target,
  input  logic              d_valid,
  input  logic              x_valid,
  output logic              br_fire,
  output logic              jp_fire,
  output logic              redir,
  output logic [ADDR_W-1:0] redir_tgt,
  output fr_pkg::kill_t     kill
);
  // Older instruction (execute) outranks younger one (decode).
  function automatic logic [ADDR_W-1:0] pick_target(input logic use_br,
                                                    input logic [ADDR_W-1:0] b,
                                                    input logic [ADDR_W-1:0] j);
    return use_br ? b : j;
  endfunction

  always_comb begin
    br_fire   = branch_taken && x_valid;
    jp_fire   = jump_taken && d_valid && !br_fire;
    redir     = br_fire || jp_fire;
    redir_tgt = pick_target(br_fire, branch_target, jump_target);
    kill.f0   = redir;
    kill.f1   = redir;
    kill.d    = br_fire;
  end
endmodule

// File: rtl/fr_pc_seq.sv
module fr_pc_seq #(
  parameter int unsigned     ADDR_W      = 32,
  parameter int unsigned     INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] START_ADDR = ADDR_W'('h100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              redir,
  input  logic [ADDR_W-1:0] redir_tgt,
  input  logic              f0_valid,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pend_v,
  output logic [ADDR_W-1:0] pend_tgt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  // A bubble in F0 means nothing was fetched there: fetch the same word again.
  function automatic logic [ADDR_W-1:0] seq_pc(input logic [ADDR_W-1:0] pc,
                                               input logic valid);
    return valid ? pc + STEP : pc;
  endfunction

  always_comb begin
    if (stall)       next_pc = pc_q;
    else if (redir)  next_pc = redir_tgt;
    else if (pend_v) next_pc = pend_tgt;
    else             next_pc = seq_pc(pc_q, f0_valid);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= START_ADDR;
      pend_v   <= 1'b0;
      pend_tgt <= '0;
    end else begin
      pc_q <= next_pc;
      if (stall && redir) begin
        pend_v   <= 1'b1;
        pend_tgt <= redir_tgt;
      end else if (!stall) begin
        pend_v   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fr_stage_track.sv
module fr_stage_track #(
  parameter int unsigned NSTAGE = fr_pkg::NSTAGE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [NSTAGE-1:0] kill,
  output logic [NSTAGE-1:0] valid
);
  logic [NSTAGE-1:0] live;
  assign live = valid & ~kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid[0] <= 1'b0;
      valid[1] <= 1'b0;
    end else begin
      valid[0] <= stall ? live[0] : 1'b1;
      valid[1] <= stall ? 1'b0 : live[0];
    end
  end

  for (genvar s = 2; s < NSTAGE; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) valid[s] <= 1'b0;
      else        valid[s] <= live[s-1];
    end
  end
endmodule

// File: rtl/fr_perf_cnt.sv
module fr_perf_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_en,
  output logic [CNT_W-1:0] retired,
  output logic [CNT_W-1:0] cycles
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v,
                                            input logic en);
    return v + CNT_W'(en);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retired <= '0;
      cycles  <= '0;
    end else begin
      retired <= bump(retired, retire_en);
      cycles  <= bump(cycles, 1'b1);
    end
  end
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl #(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       INSTR_BYTES = 4,
  parameter int unsigned       CNT_W       = 32,
  parameter logic [ADDR_W-1:0] START_ADDR  = ADDR_W'('h100)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_jump_taken,
  input  logic [ADDR_W-1:0]         dec_jump_target,
  input  logic                      exe_branch_taken,
  input  logic [ADDR_W-1:0]         exe_branch_target,
  input  logic                      icache_stall,
  output logic [ADDR_W-1:0]         fetch_pc,
  output logic [ADDR_W-1:0]         next_pc,
  output logic                      kill_f0,
  output logic                      kill_f1,
  output logic                      kill_d,
  output logic                      fetch_hold,
  output logic [fr_pkg::NSTAGE-1:0] stage_valid,
  output logic [CNT_W-1:0]          retired_count,
  output logic [CNT_W-1:0]          cycle_count
);
  import fr_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              br_fire;
  logic              jp_fire;
  logic              redir;
  logic [ADDR_W-1:0] redir_tgt;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_tgt;
  kill_t             kill;
  logic [NSTAGE-1:0] kill_vec;

  fr_redirect_arb #(.ADDR_W(ADDR_W)) i_arb (
    .jump_taken   (dec_jump_taken),
    .jump_target  (dec_jump_target),
    .branch_taken (exe_branch_taken),
    .branch_target(exe_branch_target),
    .d_valid      (stage_valid[ST_D]),
    .x_valid      (stage_valid[ST_X]),
    .br_fire      (br_fire),
    .jp_fire      (jp_fire),
    .redir        (redir),
    .redir_tgt    (redir_tgt),
    .kill         (kill)
  );

  fr_pc_seq #(
    .ADDR_W     (ADDR_W),
    .INSTR_BYTES(INSTR_BYTES),
    .START_ADDR (START_ADDR)
  ) i_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (icache_stall),
    .redir    (redir),
    .redir_tgt(redir_tgt),
    .f0_valid (stage_valid[ST_F0]),
    .pc_q     (fetch_pc),
    .next_pc  (next_pc),
    .pend_v   (pend_v),
    .pend_tgt (pend_tgt)
  );

  always_comb begin
    kill_vec        = '0;
    kill_vec[ST_F0] = kill.f0;
    kill_vec[ST_F1] = kill.f1;
    kill_vec[ST_D]  = kill.d;
  end

  fr_stage_track #(.NSTAGE(NSTAGE)) i_track (
    .clk  (clk),
    .rst_n(rst_n),
    .stall(icache_stall),
    .kill (kill_vec),
    .valid(stage_valid)
  );

  fr_perf_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .retire_en(stage_valid[ST_W]),
    .retired  (retired_count),
    .cycles   (cycle_count)
  );

  assign kill_f0    = kill.f0;
  assign kill_f1    = kill.f1;
  assign kill_d     = kill.d;
  assign fetch_hold = icache_stall;
endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned INSTR_BYTES = 4,
  parameter int unsigned CNT_W       = 32,
  parameter logic [ADDR_W-1:0] START_ADDR = ADDR_W'('h100)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              icache_stall,
  input logic              exe_branch_taken,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              kill_f0,
  input logic              kill_f1,
  input logic              kill_d,
  input logic [5:0]        stage_valid,
  input logic [CNT_W-1:0]  retired_count,
  input logic [CNT_W-1:0]  cycle_count,
  input logic              br_fire,
  input logic              jp_fire,
  input logic              redir,
  input logic [ADDR_W-1:0] redir_tgt,
  input logic              pend_v,
  input logic [ADDR_W-1:0] pend_tgt
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (fetch_pc == START_ADDR) && (stage_valid == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !icache_stall && !redir && !pend_v && stage_valid[0]
    |=> fetch_pc == $past(fetch_pc) + ADDR_W'(INSTR_BYTES));

  // R3
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir && !icache_stall
    |=> (fetch_pc == $past(redir_tgt)) && !stage_valid[1] && !stage_valid[2]);

  // R4
  branch_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exe_branch_taken && stage_valid[3] |=> !stage_valid[2] && !stage_valid[3]);

  // R5
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire |-> !jp_fire);

  // R6
  bubble_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid[2] && !stage_valid[3] |-> !kill_f0 && !kill_f1 && !kill_d);

  // R4
  kill_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_d |-> kill_f0 && kill_f1);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icache_stall |=> $stable(fetch_pc) && !stage_valid[1]);

  // R8
  pending_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v && !icache_stall && !redir |=> fetch_pc == $past(pend_tgt));

  // R9
  retire_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> retired_count == $past(retired_count) + CNT_W'($past(stage_valid[5])));

  // R10
  cycle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycle_count == $past(cycle_count) + CNT_W'(1));
endmodule

bind fetch_redirect_ctrl fr_chk #(
  .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES), .CNT_W(CNT_W), .START_ADDR(START_ADDR)
) i_fr_chk (
  .clk(clk), .rst_n(rst_n), .icache_stall(icache_stall),
  .exe_branch_taken(exe_branch_taken), .fetch_pc(fetch_pc),
  .kill_f0(kill_f0), .kill_f1(kill_f1), .kill_d(kill_d),
  .stage_valid(stage_valid), .retired_count(retired_count),
  .cycle_count(cycle_count), .br_fire(br_fire), .jp_fire(jp_fire),
  .redir(redir), .redir_tgt(redir_tgt), .pend_v(pend_v), .pend_tgt(pend_tgt)
);

// File: tb/test_fetch_redirect_ctrl.sv
module test_fetch_redirect_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jt = 1'b0, bt = 1'b0, st = 1'b0;
  logic [31:0] jtgt = '0, btgt = '0;
  logic [31:0] fetch_pc, next_pc;
  logic        kill_f0, kill_f1, kill_d, fetch_hold;
  logic [5:0]  stage_valid;
  logic [31:0] retired_count, cycle_count;

  int errors = 0;
  int checks = 0;

  // Reference state: per-stage occupancy, fetch address, remembered target.
  bit          occ[6];
  logic [31:0] m_pc;
  bit          m_pend;
  logic [31:0] m_ptgt;
  int          m_ret, m_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_redirect_ctrl i_fetch_redirect_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_jump_taken(jt), .dec_jump_target(jtgt),
    .exe_branch_taken(bt), .exe_branch_target(btgt),
    .icache_stall(st),
    .fetch_pc(fetch_pc), .next_pc(next_pc),
    .kill_f0(kill_f0), .kill_f1(kill_f1), .kill_d(kill_d),
    .fetch_hold(fetch_hold), .stage_valid(stage_valid),
    .retired_count(retired_count), .cycle_count(cycle_count)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] occ_vec();
    logic [5:0] v;
    for (int i = 0; i < 6; i++) v[i] = occ[i];
    return v;
  endfunction

  // Called at a falling edge: drive, check, advance the reference one edge.
  task automatic step(bit j, logic [31:0] jd, bit b, logic [31:0] bd, bit s);
    bit br_ok, jp_ok, any;
    logic [31:0] want_next;
    string tag;
    bit n[6];
    jt = j; jtgt = jd; bt = b; btgt = bd; st = s;
    #1;
    chk("R2 fetch_pc", fetch_pc, m_pc);
    chk("R9 stage_valid", stage_valid, occ_vec());
    chk("R9 retired", retired_count, m_ret);
    chk("R10 cycles", cycle_count, m_cyc);
    chk("R7 fetch_hold", fetch_hold, s);

    br_ok = b && occ[3];
    jp_ok = j && occ[2] && !br_ok;
    any   = br_ok || jp_ok;
    if (s)           want_next = m_pc;
    else if (br_ok)  want_next = bd;
    else if (jp_ok)  want_next = jd;
    else if (m_pend) want_next = m_ptgt;
    else             want_next = occ[0] ? m_pc + 4 : m_pc;

    if (br_ok && j && occ[2]) tag = "R5";
    else if (br_ok)           tag = "R4";
    else if (jp_ok)           tag = "R3";
    else if (j || b)          tag = "R6";
    else if (m_pend && !s)    tag = "R8";
    else if (s)               tag = "R7";
    else                      tag = "R2";
    chk({tag, " kill_f0"}, kill_f0, any);
    chk({tag, " kill_f1"}, kill_f1, any);
    chk({tag, " kill_d"}, kill_d, br_ok);
    chk({tag, " next_pc"}, next_pc, want_next);

    n[0] = s ? (occ[0] && !any) : 1'b1;
    n[1] = s ? 1'b0 : (occ[0] && !any);
    n[2] = occ[1] && !any;
    n[3] = occ[2] && !br_ok;
    n[4] = occ[3];
    n[5] = occ[4];
    @(posedge clk);
    if (occ[5]) m_ret++;
    m_cyc++;
    if (s && any) begin m_pend = 1; m_ptgt = br_ok ? bd : jd; end
    else if (!s)  m_pend = 0;
    m_pc = want_next;
    for (int i = 0; i < 6; i++) occ[i] = n[i];
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pc", fetch_pc, START);
    chk("R1 reset valid", stage_valid, 6'b0);
    chk("R1 reset retired", retired_count, 0);
    chk("R1 reset cycles", cycle_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) occ[i] = 0;
    m_pc = START; m_pend = 0; m_ptgt = '0; m_ret = 0; m_cyc = 0;

    // R1/R2: start-up refetch then sequential stepping
    repeat (8) step(0, 0, 0, 0, 0);
    // R3: jump in valid decode
    step(1, 32'h400, 0, 0, 0);
    // R6: jump while decode holds a bubble
    step(1, 32'h500, 0, 0, 0);
    repeat (4) step(0, 0, 0, 0, 0);
    // R4: branch in valid execute
    step(0, 0, 1, 32'h200, 0);
    repeat (4) step(0, 0, 0, 0, 0);
    // R5: both in one cycle
    step(1, 32'h600, 1, 32'h700, 0);
    repeat (5) step(0, 0, 0, 0, 0);
    // R7: three-cycle miss
    repeat (3) step(0, 0, 0, 0, 1);
    repeat (4) step(0, 0, 0, 0, 0);
    // R8: branch arrives during a miss
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 32'h800, 1);
    step(0, 0, 0, 0, 1);
    repeat (6) step(0, 0, 0, 0, 0);
    // R8: jump arrives on the last miss cycle
    step(1, 32'h900, 0, 0, 1);
    repeat (6) step(0, 0, 0, 0, 0);

    // Mixed traffic
    for (int k = 0; k < 3000; k++) begin
      r = $urandom;
      step(r[2:0] == 0, {r[15:8], 2'b00} + 32'h1000, r[6:4] == 0,
           {r[27:20], 2'b00} + 32'h2000, r[31:29] < 2);
    end
    repeat (8) step(0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule